// File: doc/BRIEF.md
# Register Write-Lock and One-Shot Counter Reset Controller

This block sits in front of a small register file. The file holds a configuration byte, an alarm threshold, an elapsed-time counter, an event counter and a block of user memory. Host writes arrive on a valid/ready port. Each write is decoded to one of these regions and checked against two independent, permanent write-protect locks and a one-shot counter reset. Permitted writes go on to the storage one cycle later. Dropped writes raise a one-cycle rejection pulse.

The configuration byte is held inside this block because it carries the reset-enable flag, bit 0. Host commands are single-byte codes on a second valid/ready port. One code locks the alarm and counter registers. Another code locks the user memory. A third code pulses a counter clear. The clear is accepted once only, and only while reset-enable is set. After it, the configuration byte is read-only. In normal use the host writes its configuration, alarm and memory values, then applies the locks it needs, then issues the reset.

Neither port ever applies back-pressure. Both ready outputs stay high, so a transfer takes place on every clock edge where valid is high.

Top module: `wrlock_ctrl`

## Requirements
- R1: After power-on reset (`rst_n` low), `cfg_q` is 0, both locks and `reset_done` are 0, and `fwd_we`, `wr_reject` and `cnt_clear` are 0.
- R2: The write address map is as follows: 0 is the configuration byte, 1..4 is the alarm, 5..8 is the elapsed-time counter, 9..10 is the event counter, and 11..20 is user memory. An accepted write to address 0 sets `cfg_q` to the data at the next edge and is not forwarded. An accepted write to any other mapped address drives `fwd_we` high for one cycle after the transfer edge, with that address on `fwd_addr` and that data on `fwd_data`.
- R3: Command 0x5A sets `lock_regs`. From then on, writes to the alarm, elapsed-time and event-counter addresses are dropped.
- R4: Command 0xA5 sets `lock_mem`. From then on, writes to user memory are dropped. Each lock affects only its own regions.
- R5: `lock_regs`, `lock_mem` and `reset_done` are sticky. Only `rst_n` clears them. The reset command never clears them.
- R6: Command 0x3C is accepted only while `cfg_q[0]` is 1 and `reset_done` is 0. When it is accepted, `cnt_clear` is high for exactly the one cycle after the transfer edge, `cfg_q[0]` becomes 0 and `reset_done` becomes 1. Locks do not prevent the clear.
- R7: Once `reset_done` is 1, writes to address 0 are dropped and further 0x3C commands produce no `cnt_clear`.
- R8: A dropped write leaves `fwd_we` low and raises `wr_reject` for the one cycle after the transfer edge. A write is dropped if it targets a locked region, a read-only configuration byte, or an unmapped address (21..63).
- R9: Any command code other than 0x5A, 0xA5 and 0x3C has no effect on any output.
- R10: A write is checked against the lock state that held before a command arriving on the same edge. The one exception is a configuration write on the same edge as an accepted reset command: that write is dropped.
- R11: `wr_ready` and `cmd_ready` are always 1 while out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wr_valid | input | 1 | Host write request |
| wr_ready | output | 1 | Write accepted (always high) |
| wr_addr | input | 6 | Write byte address |
| wr_data | input | 8 | Write byte |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command accepted (always high) |
| cmd_code | input | 8 | Command code |
| fwd_we | output | 1 | Write enable to register storage |
| fwd_addr | output | 6 | Forwarded address |
| fwd_data | output | 8 | Forwarded data |
| wr_reject | output | 1 | One-cycle pulse for a dropped write |
| cnt_clear | output | 1 | One-cycle clear strobe for both counters |
| cfg_q | output | 8 | Configuration byte, bit 0 is reset-enable |
| lock_regs | output | 1 | Alarm and counter lock state |
| lock_mem | output | 1 | User-memory lock state |
| reset_done | output | 1 | One-shot reset has been used |

## Verification
The hardest states to reach are the ones that follow the sticky, one-way transitions. Once a lock or the used reset is taken, only a power-on reset can undo it. Each of the four lock combinations therefore needs its own power-on reset, a setup sequence, and then a sweep over every write address. The same-edge cases in R10 also need a write and a command presented together. A dedicated task drives both valids in the same cycle for this.

// File: rtl/wrlock_pkg.sv
`timescale 1ns/1ps
package wrlock_pkg;
  typedef enum logic [2:0] {
    RG_CFG, RG_ALARM, RG_ETC, RG_EVT, RG_MEM, RG_NONE
  } region_e;

  typedef enum logic [1:0] {
    OP_NONE, OP_LOCK_REGS, OP_LOCK_MEM, OP_RESET
  } op_e;

  function automatic logic region_needs_regs_unlock(region_e r);
    return (r == RG_ALARM) || (r == RG_ETC) || (r == RG_EVT);
  endfunction
endpackage

// File: rtl/wrlock_addr_dec.sv
`timescale 1ns/1ps
module wrlock_addr_dec
  import wrlock_pkg::*;
#(
  parameter int AW          = 6,
  parameter int ALARM_BYTES = 4,
  parameter int ETC_BYTES   = 4,
  parameter int EVT_BYTES   = 2,
  parameter int MEM_BYTES   = 10
) (
  input  logic [AW-1:0] addr,
  output region_e       region
);
  localparam int NREG = 5;
  localparam int SIZES [NREG] = '{1, ALARM_BYTES, ETC_BYTES, EVT_BYTES, MEM_BYTES};
  localparam region_e KINDS [NREG] = '{RG_CFG, RG_ALARM, RG_ETC, RG_EVT, RG_MEM};

  logic [NREG-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_win
      localparam int BASE = (g == 0) ? 0 :
                            (g == 1) ? 1 :
                            (g == 2) ? 1 + ALARM_BYTES :
                            (g == 3) ? 1 + ALARM_BYTES + ETC_BYTES :
                                       1 + ALARM_BYTES + ETC_BYTES + EVT_BYTES;
      localparam int LIMIT = BASE + SIZES[g];
      assign hit[g] = (int'(addr) >= BASE) && (int'(addr) < LIMIT);
    end
  endgenerate

  always_comb begin
    region = RG_NONE;
    for (int i = 0; i < NREG; i++) begin
      if (hit[i]) region = KINDS[i];
    end
  end

  always_comb begin
    hit_onehot_chk: assert ($onehot0(hit));
  end
endmodule

// File: rtl/wrlock_cmd_dec.sv
`timescale 1ns/1ps
module wrlock_cmd_dec
  import wrlock_pkg::*;
#(
  parameter logic [7:0] CODE_LOCK_REGS = 8'h5A,
  parameter logic [7:0] CODE_LOCK_MEM  = 8'hA5,
  parameter logic [7:0] CODE_RESET     = 8'h3C
) (
  input  logic       valid,
  input  logic [7:0] code,
  output op_e        op
);
  always_comb begin
    op = OP_NONE;
    if (valid) begin
      unique case (code)
        CODE_LOCK_REGS: op = OP_LOCK_REGS;
        CODE_LOCK_MEM:  op = OP_LOCK_MEM;
        CODE_RESET:     op = OP_RESET;
        default:        op = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/wrlock_state.sv
`timescale 1ns/1ps
module wrlock_state
  import wrlock_pkg::*;
#(
  parameter int CFG_W  = 8,
  parameter int RE_BIT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  op_e              op,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             reset_accept,
  output logic [CFG_W-1:0] cfg_q,
  output logic             lock_regs,
  output logic             lock_mem,
  output logic             reset_done,
  output logic             cnt_clear
);
  assign reset_accept = (op == OP_RESET) && cfg_q[RE_BIT] && !reset_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      lock_regs  <= 1'b0;
      lock_mem   <= 1'b0;
      reset_done <= 1'b0;
      cnt_clear  <= 1'b0;
    end else begin
      cnt_clear <= reset_accept;
      if (op == OP_LOCK_REGS) lock_regs <= 1'b1;
      if (op == OP_LOCK_MEM)  lock_mem  <= 1'b1;
      if (reset_accept) begin
        reset_done    <= 1'b1;
        cfg_q[RE_BIT] <= 1'b0;
      end else if (cfg_we) begin
        cfg_q <= cfg_wdata;
      end
    end
  end

  // R5
  lock_regs_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_regs |=> lock_regs);
  // R5
  lock_mem_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_mem |=> lock_mem);
  // R5
  reset_done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_done |=> reset_done);
  // R6
  clear_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |-> !$past(reset_done) && reset_done && !cfg_q[RE_BIT]);
  // R7
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_done |=> $stable(cfg_q));
endmodule

// File: rtl/wrlock_gate.sv
`timescale 1ns/1ps
module wrlock_gate
  import wrlock_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  region_e       region,
  input  logic          lock_regs,
  input  logic          lock_mem,
  input  logic          reset_done,
  input  logic          reset_accept,
  output logic          cfg_we,
  output logic          fwd_we,
  output logic [AW-1:0] fwd_addr,
  output logic [DW-1:0] fwd_data,
  output logic          wr_reject
);
  logic allow;

  always_comb begin
    unique case (region)
      RG_CFG:                   allow = !reset_done && !reset_accept;
      RG_ALARM, RG_ETC, RG_EVT: allow = !lock_regs;
      RG_MEM:                   allow = !lock_mem;
      default:                  allow = 1'b0;
    endcase
  end

  assign cfg_we = wr_valid && allow && (region == RG_CFG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_we    <= 1'b0;
      fwd_addr  <= '0;
      fwd_data  <= '0;
      wr_reject <= 1'b0;
    end else begin
      fwd_we    <= wr_valid && allow && (region != RG_CFG);
      wr_reject <= wr_valid && !allow;
      if (wr_valid) begin
        fwd_addr <= wr_addr;
        fwd_data <= wr_data;
      end
    end
  end

  // R8
  reject_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |-> !fwd_we);
  // R2
  fwd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_we || wr_reject) |-> $past(wr_valid));
  // R3
  regs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && lock_regs && region_needs_regs_unlock(region)) |=> !fwd_we && wr_reject);
  // R4
  mem_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && lock_mem && region == RG_MEM) |=> !fwd_we && wr_reject);
endmodule

// File: rtl/wrlock_ctrl.sv
`timescale 1ns/1ps
module wrlock_ctrl
  import wrlock_pkg::*;
#(
  parameter int         AW             = 6,
  parameter int         DW             = 8,
  parameter int         ALARM_BYTES    = 4,
  parameter int         ETC_BYTES      = 4,
  parameter int         EVT_BYTES      = 2,
  parameter int         MEM_BYTES      = 10,
  parameter int         RE_BIT         = 0,
  parameter logic [7:0] CODE_LOCK_REGS = 8'h5A,
  parameter logic [7:0] CODE_LOCK_MEM  = 8'hA5,
  parameter logic [7:0] CODE_RESET     = 8'h3C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [7:0]    cmd_code,
  output logic          fwd_we,
  output logic [AW-1:0] fwd_addr,
  output logic [DW-1:0] fwd_data,
  output logic          wr_reject,
  output logic          cnt_clear,
  output logic [DW-1:0] cfg_q,
  output logic          lock_regs,
  output logic          lock_mem,
  output logic          reset_done
);
  region_e region;
  op_e     op;
  logic    reset_accept;
  logic    cfg_we;

  assign wr_ready  = 1'b1;
  assign cmd_ready = 1'b1;

  wrlock_addr_dec #(
    .AW(AW), .ALARM_BYTES(ALARM_BYTES), .ETC_BYTES(ETC_BYTES),
    .EVT_BYTES(EVT_BYTES), .MEM_BYTES(MEM_BYTES)
  ) u_addr (
    .addr(wr_addr), .region(region)
  );

  wrlock_cmd_dec #(
    .CODE_LOCK_REGS(CODE_LOCK_REGS), .CODE_LOCK_MEM(CODE_LOCK_MEM),
    .CODE_RESET(CODE_RESET)
  ) u_cmd (
    .valid(cmd_valid), .code(cmd_code), .op(op)
  );

  wrlock_state #(.CFG_W(DW), .RE_BIT(RE_BIT)) u_state (
    .clk(clk), .rst_n(rst_n), .op(op), .cfg_we(cfg_we), .cfg_wdata(wr_data),
    .reset_accept(reset_accept), .cfg_q(cfg_q), .lock_regs(lock_regs),
    .lock_mem(lock_mem), .reset_done(reset_done), .cnt_clear(cnt_clear)
  );

  wrlock_gate #(.AW(AW), .DW(DW)) u_gate (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .region(region), .lock_regs(lock_regs),
    .lock_mem(lock_mem), .reset_done(reset_done), .reset_accept(reset_accept),
    .cfg_we(cfg_we), .fwd_we(fwd_we), .fwd_addr(fwd_addr), .fwd_data(fwd_data),
    .wr_reject(wr_reject)
  );

  // R9
  unknown_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == OP_NONE && !wr_valid) |=>
      !cnt_clear && $stable(lock_regs) && $stable(lock_mem) && $stable(cfg_q));
endmodule

// File: tb/wrlock_ctrl_test.sv
`timescale 1ns/1ps
module wrlock_ctrl_test;
  localparam int AW = 6;
  localparam logic [7:0] C_LR = 8'h5A, C_LM = 8'hA5, C_RS = 8'h3C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, cmd_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0, cmd_code = '0;
  logic wr_ready, cmd_ready, fwd_we, wr_reject, cnt_clear, lock_regs, lock_mem, reset_done;
  logic [AW-1:0] fwd_addr;
  logic [7:0] fwd_data, cfg_q;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  wrlock_ctrl uut (.*);

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // 0 cfg, 1 regs-locked class, 2 mem, 3 unmapped
  function automatic int cls(int a);
    if (a == 0) return 0;
    if (a <= 10) return 1;
    if (a <= 20) return 2;
    return 3;
  endfunction

  task automatic por();
    @(negedge clk); rst_n = 1'b0; wr_valid = 0; cmd_valid = 0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic both(logic wv, int a, logic [7:0] d, logic cv, logic [7:0] c);
    @(negedge clk);
    wr_valid = wv; wr_addr = AW'(a); wr_data = d; cmd_valid = cv; cmd_code = c;
    @(negedge clk);
    wr_valid = 0; cmd_valid = 0;
  endtask

  task automatic wr(int a, logic [7:0] d); both(1, a, d, 0, 8'h00); endtask
  task automatic cmd(logic [7:0] c); both(0, 0, 8'h00, 1, c); endtask

  initial begin
    por();
    // R1
    chk("R1 cfg", cfg_q, 0); chk("R1 locks", {lock_regs, lock_mem, reset_done}, 0);
    chk("R1 strobes", {fwd_we, wr_reject, cnt_clear}, 0);
    // R11
    chk("R11 ready", {wr_ready, cmd_ready}, 2'b11);

    // R2 R3 R4 R8: sweep every address under every lock combination
    for (int lc = 0; lc < 4; lc++) begin
      por();
      wr(0, 8'h01);
      if (lc[0]) cmd(C_LR);
      if (lc[1]) cmd(C_LM);
      chk("R3/R4 lock bits", {lock_regs, lock_mem}, {lc[0] ? 1'b1 : 1'b0, lc[1] ? 1'b1 : 1'b0});
      for (int a = 0; a < 64; a++) begin
        logic [7:0] d;
        bit ok;
        int c;
        d = 8'((a * 7 + lc * 3) ^ 8'h5A);
        c = cls(a);
        ok = (c == 0) || (c == 1 && !lc[0]) || (c == 2 && !lc[1]);
        wr(a, d);
        chk(c == 1 ? "R3 regs gate" : c == 2 ? "R4 mem gate" : "R2 map",
            fwd_we, (ok && c != 0) ? 1 : 0);
        chk("R8 reject", wr_reject, ok ? 0 : 1);
        if (ok && c != 0) chk("R2 fwd addr/data", {fwd_addr, fwd_data}, {AW'(a), d});
        if (c == 0) chk("R2 cfg write", cfg_q, d);
      end
    end

    // R9: unknown codes leave everything unchanged (RE set so a stray reset would show)
    por();
    wr(0, 8'h81);
    for (int k = 0; k < 256; k++) begin
      if (k == C_LR || k == C_LM || k == C_RS) continue;
      cmd(8'(k));
      if (cnt_clear || lock_regs || lock_mem || reset_done || cfg_q != 8'h81)
        chk("R9 unknown code", {cnt_clear, lock_regs, lock_mem, reset_done, cfg_q}, {4'b0, 8'h81});
    end
    chk("R9 after sweep", {lock_regs, lock_mem, reset_done, cfg_q}, {3'b0, 8'h81});

    // R6: reset refused while RE is 0
    por();
    wr(0, 8'hF0); cmd(C_RS);
    chk("R6 refused RE=0", {cnt_clear, reset_done}, 0);
    // R6/R5: locked, then accepted reset
    wr(0, 8'hF1); cmd(C_LR); cmd(C_LM); cmd(C_RS);
    chk("R6 clear pulse", cnt_clear, 1);
    chk("R6 cfg RE cleared", cfg_q, 8'hF0);
    chk("R6 done", reset_done, 1);
    chk("R5 locks kept", {lock_regs, lock_mem}, 2'b11);
    @(negedge clk);
    chk("R6 pulse width", cnt_clear, 0);
    // R7
    wr(0, 8'h01);
    chk("R7 cfg read-only", {cfg_q, wr_reject}, {8'hF0, 1'b1});
    cmd(C_RS);
    chk("R7 second reset", cnt_clear, 0);
    // R5: power-on reset clears
    por();
    chk("R5 por clears", {lock_regs, lock_mem, reset_done}, 0);

    // R10: lock and write on the same edge uses the old lock state
    both(1, 2, 8'h33, 1, C_LR);
    chk("R10 same-edge write", {fwd_we, fwd_addr, fwd_data}, {1'b1, 6'd2, 8'h33});
    wr(2, 8'h34);
    chk("R10 next write", {fwd_we, wr_reject}, 2'b01);
    // R10: cfg write with accepted reset is dropped
    wr(0, 8'h01);
    both(1, 0, 8'hC1, 1, C_RS);
    chk("R10 reset wins", {cnt_clear, wr_reject, cfg_q}, {2'b11, 8'h00});

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule